// File: doc/BRIEF.md
# Inter-Bit Gap Watchdog

This block sits beside the token receiver of a half-duplex single-wire device. It watches the gaps between received bits and asks the device to sleep when the host stalls part-way through a token or a command block. The receiver reports events to it: a token's leading edge, each received bit, a legal token completing, a legal command flag, the last bit the command block should contain, and the running length of the current low pulse.

A leading edge arms a token watch. A legal command flag arms a block watch, which stays armed until the last expected bit arrives. While armed, a gap counter counts the cycles since the last restart event. A received bit or a legal token clears it, so a long block is fine as long as no single gap is too long. A low pulse longer than the configured maximum marks the token illegal. From then on nothing clears the counter, and the watchdog fires when it runs out. When it fires it drives a one-cycle sleep request and disarms. The gap limit and the maximum low length are sampled when the watchdog arms.

States: WD_IDLE (disarmed, counter held at zero), WD_TOKEN (inside a token), WD_BLOCK (inside a command block), WD_POISON (illegal low pulse seen, waiting out the interval). The FSM makes these transitions:
- WD_IDLE goes to WD_BLOCK on a command flag, or to WD_TOKEN on a leading edge.
- WD_TOKEN goes to WD_BLOCK on a command flag, or to WD_IDLE on a legal token.
- WD_BLOCK goes to WD_IDLE on the last expected bit.
- WD_TOKEN or WD_BLOCK goes to WD_POISON on an over-long low pulse.
- Any armed state goes to WD_IDLE on expiry, with a sleep pulse.

Top module: `bitgap_watchdog`

## Requirements
- R1: After reset the watchdog is disarmed and sleep_req is 0.
- R2: In WD_IDLE, tok_lead arms a token watch and cmd_flag_ok arms a block watch. When both are asserted together, the block watch is chosen. Arming clears the gap count to 0.
- R3: While armed with limit T and no restart event, sleep_req rises in the cycle when the gap count equals T, which is T cycles after the arming or restart edge.
- R4: While armed and not poisoned, bit_rx, tok_ok, tok_lead or cmd_flag_ok clears the gap count. The total length of a block is therefore unbounded.
- R5: In WD_TOKEN, tok_ok disarms. In WD_BLOCK, last_bit disarms, and tok_ok does not.
- R6: While armed, low_len > cfg_low_max (as sampled at arming) poisons the watch. After that, restart events and last_bit are ignored, and sleep_req fires when the count reaches T. low_len equal to the maximum is legal.
- R7: When disarmed, the gap count is 0 and sleep_req stays 0 whatever the events.
- R8: sleep_req is a single-cycle pulse, and the watchdog is disarmed in the following cycle.
- R9: cfg_gap_max and cfg_low_max are sampled only when arming from WD_IDLE. Later changes have no effect until the next arming.
- R10: With a limit of 0, sleep_req fires in the first cycle after arming unless a restart event is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tok_lead | input | 1 | Leading transition of a data token |
| bit_rx | input | 1 | One bit of a token received |
| tok_ok | input | 1 | A legal token completed |
| cmd_flag_ok | input | 1 | A legal command flag was received |
| last_bit | input | 1 | Last expected bit of the command block |
| low_len | input | LOW_W | Length in cycles of the current low pulse |
| cfg_gap_max | input | CNT_W | Gap limit in cycles |
| cfg_low_max | input | LOW_W | Longest legal low pulse in cycles |
| sleep_req | output | 1 | One-cycle sleep request |

## Verification
Assertions run on every cycle. They check that the sleep pulse lasts one cycle and is always followed by the disarmed state. They check that the disarmed state keeps the counter at zero and never requests sleep. They also check that a poisoned watch stays poisoned until it fires, that the gap count never passes its latched limit, and that the latched limits change only on arming. Only the bench's scenarios can show the exact firing cycle after a restart, unbounded block length with regular bits, the precedence of the command flag, the boundary at a low length equal to the maximum, and that configuration changes after arming are ignored.

// File: rtl/bitgap_wdg_pkg.sv
package bitgap_wdg_pkg;
    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_TOKEN  = 2'd1,
        WD_BLOCK  = 2'd2,
        WD_POISON = 2'd3
    } wd_state_e;
endpackage

// File: rtl/bitgap_cfg_hold.sv
module bitgap_cfg_hold #(
    parameter int CNT_W = 16,
    parameter int LOW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] gap_in,
    input  logic [LOW_W-1:0] low_in,
    input  logic [LOW_W-1:0] low_len,
    output logic [CNT_W-1:0] gap_lim,
    output logic             low_over
);
    logic [LOW_W-1:0] low_lim_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_lim   <= '0;
            low_lim_q <= '0;
        end else if (load) begin
            gap_lim   <= gap_in;
            low_lim_q <= low_in;
        end
    end

    assign low_over = (low_len > low_lim_q);

    // limits move only on arming
    assert_cfg_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(gap_lim) && $stable(low_lim_q)));
endmodule

// File: rtl/bitgap_gap_ctr.sv
module bitgap_gap_ctr #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] count,
    output logic             at_limit
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (inc)    count <= count + 1'b1;
    end

    assign at_limit = (count == limit);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        count <= limit);
endmodule

// File: rtl/bitgap_watchdog.sv
module bitgap_watchdog
    import bitgap_wdg_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int LOW_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tok_lead,
    input  logic             bit_rx,
    input  logic             tok_ok,
    input  logic             cmd_flag_ok,
    input  logic             last_bit,
    input  logic [LOW_W-1:0] low_len,
    input  logic [CNT_W-1:0] cfg_gap_max,
    input  logic [LOW_W-1:0] cfg_low_max,
    output logic             sleep_req
);
    wd_state_e        st_q, st_d;
    logic             cnt_clr, cnt_inc, cfg_load, fire;
    logic             at_lim, over;
    logic [CNT_W-1:0] gap_lim, gap_cnt;
    logic             restart;

    bitgap_cfg_hold #(.CNT_W(CNT_W), .LOW_W(LOW_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(cfg_load),
        .gap_in(cfg_gap_max), .low_in(cfg_low_max), .low_len(low_len),
        .gap_lim(gap_lim), .low_over(over)
    );

    bitgap_gap_ctr #(.CNT_W(CNT_W)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .inc(cnt_inc),
        .limit(gap_lim), .count(gap_cnt), .at_limit(at_lim)
    );

    assign restart = bit_rx | tok_ok | tok_lead | cmd_flag_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= WD_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d     = st_q;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        cfg_load = 1'b0;
        fire     = 1'b0;
        unique case (st_q)
            WD_IDLE: begin
                cnt_clr = 1'b1;
                if (cmd_flag_ok) begin
                    st_d     = WD_BLOCK;
                    cfg_load = 1'b1;
                end else if (tok_lead) begin
                    st_d     = WD_TOKEN;
                    cfg_load = 1'b1;
                end
            end
            WD_TOKEN, WD_BLOCK: begin
                if (st_q == WD_TOKEN && cmd_flag_ok && !over) begin
                    st_d    = WD_BLOCK;
                    cnt_clr = 1'b1;
                end else if (st_q == WD_TOKEN && tok_ok && !over) begin
                    st_d    = WD_IDLE;
                    cnt_clr = 1'b1;
                end else if (st_q == WD_BLOCK && last_bit && !over) begin
                    st_d    = WD_IDLE;
                    cnt_clr = 1'b1;
                end else if (over) begin
                    if (at_lim) begin
                        fire    = 1'b1;
                        st_d    = WD_IDLE;
                        cnt_clr = 1'b1;
                    end else begin
                        st_d    = WD_POISON;
                        cnt_inc = 1'b1;
                    end
                end else if (restart) begin
                    cnt_clr = 1'b1;
                end else if (at_lim) begin
                    fire    = 1'b1;
                    st_d    = WD_IDLE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            WD_POISON: begin
                if (at_lim) begin
                    fire    = 1'b1;
                    st_d    = WD_IDLE;
                    cnt_clr = 1'b1;
                end else begin
                    cnt_inc = 1'b1;
                end
            end
            default: st_d = WD_IDLE;
        endcase
    end

    always_comb begin
        sleep_req = fire;
    end

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> !sleep_req);
    assert_disarm_after_R8: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |=> (st_q == WD_IDLE));
    assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_IDLE) |-> (!sleep_req && gap_cnt == '0));
    assert_poison_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == WD_POISON && !sleep_req) |=> (st_q == WD_POISON));
endmodule

// File: tb/tb_bitgap_watchdog.sv
module tb_bitgap_watchdog;
    localparam int CNT_W = 16;
    localparam int LOW_W = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tok_lead = 0, bit_rx = 0, tok_ok = 0, cmd_flag_ok = 0, last_bit = 0;
    logic [LOW_W-1:0] low_len = '0;
    logic [CNT_W-1:0] cfg_gap_max = 16'd5;
    logic [LOW_W-1:0] cfg_low_max = 12'd10;
    logic sleep_req;

    int compared = 0, mismatched = 0;
    string cur_req = "R1";
    bit done = 0;

    // reference model: 0 idle, 1 token, 2 block, 3 poisoned
    int m_st = 0, m_cnt = 0, m_lim = 0, m_low = 0;

    bitgap_watchdog #(.CNT_W(CNT_W), .LOW_W(LOW_W)) dut (
        .clk(clk), .rst_n(rst_n), .tok_lead(tok_lead), .bit_rx(bit_rx),
        .tok_ok(tok_ok), .cmd_flag_ok(cmd_flag_ok), .last_bit(last_bit),
        .low_len(low_len), .cfg_gap_max(cfg_gap_max), .cfg_low_max(cfg_low_max),
        .sleep_req(sleep_req)
    );

    always #10 clk = ~clk;

    task automatic model_eval(output int ns, output int nc, output int nl,
                              output int nm, output bit f);
        bit bad;
        bad = (int'(low_len) > m_low);
        ns = m_st; nc = m_cnt; nl = m_lim; nm = m_low; f = 0;
        if (m_st == 0) begin
            nc = 0;
            if (cmd_flag_ok || tok_lead) begin
                ns = cmd_flag_ok ? 2 : 1;
                nl = int'(cfg_gap_max); nm = int'(cfg_low_max);
            end
        end else if (m_st == 3 || bad) begin
            if (m_cnt == m_lim) begin f = 1; ns = 0; nc = 0; end
            else begin ns = 3; nc = m_cnt + 1; end
            if (m_st != 3 && !bad) ns = m_st;
        end
        if (m_st == 1 || m_st == 2) begin
            if (!bad) begin
                if (m_st == 1 && cmd_flag_ok) begin ns = 2; nc = 0; end
                else if (m_st == 1 && tok_ok) begin ns = 0; nc = 0; end
                else if (m_st == 2 && last_bit) begin ns = 0; nc = 0; end
                else if (bit_rx || tok_ok || tok_lead || cmd_flag_ok) nc = 0;
                else if (m_cnt == m_lim) begin f = 1; ns = 0; nc = 0; end
                else nc = m_cnt + 1;
            end
        end
    endtask

    always @(posedge clk or negedge rst_n) begin
        int ns, nc, nl, nm; bit f;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_lim = 0; m_low = 0;
        end else begin
            model_eval(ns, nc, nl, nm, f);
            m_st = ns; m_cnt = nc; m_lim = nl; m_low = nm;
        end
    end

    always @(negedge clk) begin
        int ns, nc, nl, nm; bit f;
        if (!done) begin
            if (!rst_n) f = 0;
            else model_eval(ns, nc, nl, nm, f);
            compared++;
            if (sleep_req !== f) begin
                mismatched++;
                $display("FAIL %s: sleep_req actual %0b expected %0b at %0t",
                         cur_req, sleep_req, f, $time);
            end
        end
    end

    task automatic step(input bit l, input bit b, input bit o, input bit c,
                        input bit lb, input int ll);
        tok_lead = l; bit_rx = b; tok_ok = o; cmd_flag_ok = c; last_bit = lb;
        low_len = LOW_W'(ll);
        @(posedge clk); #1;
        tok_lead = 0; bit_rx = 0; tok_ok = 0; cmd_flag_ok = 0; last_bit = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic finish_run();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: actual hung expected finished");
            finish_run();
        end
    end

    initial begin
        cur_req = "R1"; repeat (3) @(posedge clk); #1 rst_n = 1'b1;
        cur_req = "R7"; idle(4);
        step(0, 1, 1, 0, 1, 20); idle(3);           // events while disarmed
        cur_req = "R3"; step(1, 0, 0, 0, 0, 0); idle(10);   // R2 token arm, fires
        cur_req = "R8"; idle(3);
        cur_req = "R4";                               // bits keep token alive
        step(1, 0, 0, 0, 0, 0);
        for (int i = 0; i < 6; i++) begin idle(3); step(0, 1, 0, 0, 0, 0); end
        cur_req = "R5"; step(0, 0, 1, 0, 0, 0); idle(12);
        cur_req = "R4";                               // long block
        step(0, 0, 0, 1, 0, 0);
        for (int i = 0; i < 20; i++) begin idle(4); step(0, 1, 0, 0, 0, 0); end
        cur_req = "R5"; step(0, 0, 1, 0, 0, 0); idle(3);
        step(0, 0, 0, 0, 1, 0); idle(12);
        cur_req = "R3"; step(0, 0, 0, 1, 0, 0); idle(2);
        step(0, 1, 0, 0, 0, 0); idle(9);
        cur_req = "R6";                               // overlong low
        step(1, 0, 0, 0, 0, 0); idle(1);
        step(0, 1, 0, 0, 0, 11); step(0, 1, 1, 0, 0, 0); step(0, 1, 0, 0, 0, 0);
        idle(8);
        step(0, 0, 0, 1, 0, 0);                       // equal length is legal
        for (int i = 0; i < 5; i++) begin idle(2); step(0, 1, 0, 0, 0, 10); end
        step(0, 0, 0, 0, 1, 14); step(0, 1, 0, 0, 1, 0); idle(8);
        cur_req = "R9"; step(1, 0, 0, 0, 0, 0);
        cfg_gap_max = 16'd50; cfg_low_max = 12'd0;
        step(0, 0, 0, 0, 0, 3); idle(8);
        cfg_gap_max = 16'd5; cfg_low_max = 12'd10;
        cur_req = "R2"; step(1, 0, 0, 1, 0, 0);       // both: block wins
        step(0, 0, 1, 0, 0, 0); idle(9);
        cur_req = "R10"; cfg_gap_max = 16'd0;
        step(1, 0, 0, 0, 0, 0); step(0, 1, 0, 0, 0, 0); idle(3);
        step(0, 0, 0, 1, 0, 0); idle(3);
        cfg_gap_max = 16'd5;
        finish_run();
    end
endmodule